// File: doc/BRIEF.md
# Oscillator Startup Clock Gating Controller

This block sequences a high-speed oscillator and decides when its clock may reach the peripherals. It asks for the oscillator by driving `osc_en`. It counts rising edges of the raw oscillator clock and opens a glitch-free gate on that clock only after a stabilization count has elapsed. The block raises `osc_en` itself at power-on, without any software action. At power-on the count is long (8192 edges by default), and the CPU is held in reset until that count completes. The CPU reset release and the peripheral clock release happen in the same control-clock cycle.

Once the CPU is running, three inputs control the oscillator. A software enable bit starts or stops it. A stop request shuts it down for a low-power sleep, and only an external wake interrupt brings it back. Every restart uses the short count, 128 edges by default. If a restart is interrupted by a stop request or by clearing the enable bit, the count is thrown away, and the next start counts from zero.

The control logic runs on a separate control clock, `clk`. The edge counter runs on the oscillator clock. A run request crosses into the oscillator domain and a done flag crosses back, each through a synchronizer of `SYNC_STAGES` flops. The gate enable is held in a latch that is transparent only while the oscillator clock is low.

Top module: `osc_startup_gate`

## Requirements
- R1: While `por` is high, `osc_en` is 1, `cpu_rst_n` is 0, `clk_stable` is 0 and `pclk` stays low.
- R2: After `por` falls, `clk_stable` and `cpu_rst_n` rise in the same control cycle. No fewer than COLD_COUNT oscillator rising edges and no more than COLD_COUNT+40 lie between the fall of `por` and that cycle.
- R3: Until `cpu_rst_n` has risen, `stop_req`, `wake_irq` and a low `enosc` have no effect: `osc_en` stays 1 and the power-on count completes inside the R2 window.
- R4: While running, a one-cycle `stop_req` makes `osc_en` and `clk_stable` 0 in the next control cycle, and `pclk` then produces no further pulses.
- R5: In sleep, a `wake_irq` with `enosc` high raises `osc_en` in the next cycle. `clk_stable` follows after no fewer than WARM_COUNT and no more than WARM_COUNT+40 oscillator rising edges.
- R6: While running, `enosc` low makes `osc_en` 0 in the next control cycle. Raising `enosc` again restarts the oscillator with the WARM_COUNT window of R5.
- R7: A stop request during a restart count aborts it with `clk_stable` still 0. The following restart again needs the full WARM_COUNT window.
- R8: Every `pclk` high pulse lasts exactly one high phase of `osc_clk`. `pclk` pulses while `clk_stable` is 1, and none occur once `clk_stable` has been 0 for more than three control cycles.
- R9: `stop_req` takes priority over `enosc` low. In sleep, `enosc` alone does not restart the oscillator. A wake with `enosc` low leads to the off state, from which raising `enosc` restarts the oscillator without a wake.
- R10: `wake_irq` is ignored outside sleep. Once released, `cpu_rst_n` never falls again while `por` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por | input | 1 | Power-on reset, active high, held for several cycles of both clocks |
| enosc | input | 1 | Software oscillator enable bit |
| stop_req | input | 1 | Request to enter sleep, sampled on `clk` |
| wake_irq | input | 1 | External wake interrupt, sampled on `clk` |
| osc_clk | input | 1 | Raw high-speed oscillator clock |
| osc_en | output | 1 | Oscillator run request |
| pclk | output | 1 | Gated peripheral clock |
| clk_stable | output | 1 | Peripheral clock released and stable |
| cpu_rst_n | output | 1 | CPU reset release, active low reset |

## Verification
The assertions take `enosc`, `stop_req` and `wake_irq` as synchronous to `clk`, each held for at least one full control cycle. They also take it that `osc_clk` toggles whenever `osc_en` is high, so a started count always completes. The bench changes every control input just after a falling edge of `clk`, pulses requests for exactly one cycle, and runs `osc_clk` freely at 2.5 times the control frequency. The timing windows are therefore measured against a fixed clock ratio.

// File: rtl/oscg_pkg.sv
package oscg_pkg;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_COUNT,
        ST_ON,
        ST_OFF,
        ST_SLEEP
    } oscg_state_e;

    // Request carried into the oscillator domain.
    typedef struct packed {
        logic run;
        logic long_sel;
    } cnt_req_t;

    // Number of oscillator edges to wait for the selected start kind.
    function automatic int unsigned stab_len(logic long_sel, int unsigned cold_n,
                                             int unsigned warm_n);
        return long_sel ? cold_n : warm_n;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/oscg_sync.sv
module oscg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/oscg_counter.sv
module oscg_counter
    import oscg_pkg::*;
#(
    parameter int COLD_COUNT  = 8192,
    parameter int WARM_COUNT  = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic     osc_clk,
    input  logic     por,
    input  cnt_req_t req,
    output logic     done
);
    localparam int CW = $clog2(max_u(COLD_COUNT, WARM_COUNT) + 1);

    cnt_req_t       req_s;
    logic           rst_o;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  last_q;

    oscg_sync #(.STAGES(SYNC_STAGES), .W($bits(cnt_req_t))) u_req_sync (
        .clk (osc_clk),
        .d   (req),
        .q   (req_s)
    );

    oscg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_sync (
        .clk (osc_clk),
        .d   (por),
        .q   (rst_o)
    );

    always_comb begin
        last_q = CW'(stab_len(req_s.long_sel, COLD_COUNT, WARM_COUNT) - 1);
    end

    always_ff @(posedge osc_clk) begin
        if (rst_o || !req_s.run) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == last_q) begin
                done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/oscg_clkgate.sv
module oscg_clkgate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic gate_req,
    output logic gclk
);
    logic gate_s;
    logic gate_lat;

    oscg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_gate_sync (
        .clk (osc_clk),
        .d   (gate_req),
        .q   (gate_s)
    );

    // Transparent only in the low phase: the enable cannot change mid-pulse.
    always_latch begin
        if (!osc_clk) begin
            gate_lat = gate_s;
        end
    end

    assign gclk = osc_clk & gate_lat;
endmodule

// File: rtl/oscg_ctrl.sv
module oscg_ctrl
    import oscg_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     enosc,
    input  logic     stop_req,
    input  logic     wake_irq,
    input  logic     done_s,
    output cnt_req_t req,
    output logic     osc_en,
    output logic     gate_req,
    output logic     clk_stable,
    output logic     cpu_rst_n
);
    oscg_state_e st, st_nx;
    logic        cold;
    logic        active;

    assign active = (st == ST_ARM) || (st == ST_COUNT) || (st == ST_ON);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARM:   if (!done_s) st_nx = ST_COUNT;
            ST_COUNT: if (done_s)  st_nx = ST_ON;
            ST_ON:    st_nx = ST_ON;
            ST_OFF:   if (enosc)   st_nx = ST_ARM;
            ST_SLEEP: if (wake_irq) st_nx = enosc ? ST_ARM : ST_OFF;
            default:  st_nx = ST_ARM;
        endcase
        if (!cold) begin
            if (active || st == ST_OFF) begin
                if (stop_req) begin
                    st_nx = ST_SLEEP;
                end else if (active && !enosc) begin
                    st_nx = ST_OFF;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st   <= ST_ARM;
            cold <= 1'b1;
        end else begin
            st <= st_nx;
            if (st == ST_COUNT && done_s) begin
                cold <= 1'b0;
            end
        end
    end

    always_comb begin
        req.run      = (st == ST_COUNT) || (st == ST_ON);
        req.long_sel = cold;
    end

    assign osc_en     = active;
    assign gate_req   = (st == ST_ON);
    assign clk_stable = (st == ST_ON);
    assign cpu_rst_n  = !cold;
endmodule

// File: rtl/osc_startup_gate.sv
module osc_startup_gate
    import oscg_pkg::*;
#(
    parameter int COLD_COUNT  = 8192,
    parameter int WARM_COUNT  = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic enosc,
    input  logic stop_req,
    input  logic wake_irq,
    input  logic osc_clk,
    output logic osc_en,
    output logic pclk,
    output logic clk_stable,
    output logic cpu_rst_n
);
    cnt_req_t req;
    logic     done;
    logic     done_s;
    logic     gate_req;

    oscg_ctrl u_ctrl (
        .clk        (clk),
        .por        (por),
        .enosc      (enosc),
        .stop_req   (stop_req),
        .wake_irq   (wake_irq),
        .done_s     (done_s),
        .req        (req),
        .osc_en     (osc_en),
        .gate_req   (gate_req),
        .clk_stable (clk_stable),
        .cpu_rst_n  (cpu_rst_n)
    );

    oscg_counter #(
        .COLD_COUNT  (COLD_COUNT),
        .WARM_COUNT  (WARM_COUNT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_counter (
        .osc_clk (osc_clk),
        .por     (por),
        .req     (req),
        .done    (done)
    );

    oscg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_done_sync (
        .clk (clk),
        .d   (done),
        .q   (done_s)
    );

    oscg_clkgate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .osc_clk  (osc_clk),
        .gate_req (gate_req),
        .gclk     (pclk)
    );
endmodule

// File: rtl/osc_startup_gate_chk.sv
module osc_startup_gate_chk (
    input logic clk,
    input logic por,
    input logic enosc,
    input logic stop_req,
    input logic wake_irq,
    input logic osc_en,
    input logic clk_stable,
    input logic cpu_rst_n
);
    assert_cold_osc_on_R3: assert property (@(posedge clk) disable iff (por)
        !cpu_rst_n |-> osc_en);

    assert_stable_after_release_R2: assert property (@(posedge clk) disable iff (por)
        clk_stable |-> cpu_rst_n);

    assert_stable_needs_osc_R4: assert property (@(posedge clk) disable iff (por)
        clk_stable |-> osc_en);

    assert_stop_halts_R4: assert property (@(posedge clk) disable iff (por)
        (stop_req && cpu_rst_n) |=> !osc_en);

    assert_clear_halts_R6: assert property (@(posedge clk) disable iff (por)
        (!enosc && cpu_rst_n) |=> !osc_en);

    assert_wake_restarts_R5: assert property (@(posedge clk) disable iff (por)
        (cpu_rst_n && !osc_en && wake_irq && enosc && !stop_req) |=> osc_en);

    assert_no_reset_again_R10: assert property (@(posedge clk) disable iff (por)
        !$fell(cpu_rst_n));
endmodule

bind osc_startup_gate osc_startup_gate_chk u_chk (
    .clk        (clk),
    .por        (por),
    .enosc      (enosc),
    .stop_req   (stop_req),
    .wake_irq   (wake_irq),
    .osc_en     (osc_en),
    .clk_stable (clk_stable),
    .cpu_rst_n  (cpu_rst_n)
);

// File: tb/osc_startup_gate_bench.sv
module osc_startup_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OSC_HALF   = 2;
    localparam int COLD_N     = 8192;
    localparam int WARM_N     = 128;
    localparam int SLACK      = 40;

    logic clk = 1'b0, osc_clk = 1'b0;
    logic por = 1'b1, enosc = 1'b1, stop_req = 1'b0, wake_irq = 1'b0;
    logic osc_en, pclk, clk_stable, cpu_rst_n;

    int    errors = 0, checks = 0;
    longint osc_edges = 0;
    int    low_age = 0, glitch_bad = 0, pulses = 0;
    time   pclk_rise = 0;
    bit    finished = 1'b0;

    osc_startup_gate #(.COLD_COUNT(COLD_N), .WARM_COUNT(WARM_N)) u_osc_startup_gate (
        .clk (clk), .por (por), .enosc (enosc), .stop_req (stop_req),
        .wake_irq (wake_irq), .osc_clk (osc_clk), .osc_en (osc_en),
        .pclk (pclk), .clk_stable (clk_stable), .cpu_rst_n (cpu_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(OSC_HALF) osc_clk = ~osc_clk;
    always @(posedge osc_clk) osc_edges <= osc_edges + 1;
    always @(negedge clk) low_age <= clk_stable ? 0 : low_age + 1;

    // R8 monitors: pulse width and pulses after the gate should be shut
    always @(posedge pclk) begin
        pclk_rise = $time;
        pulses++;
        if (!clk_stable && low_age > 3) glitch_bad++;
    end
    always @(negedge pclk) begin
        if (pulses > 0 && ($time - pclk_rise) != OSC_HALF) glitch_bad++;
    end

    task automatic check(string tag, bit ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; cyc(1); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;
    endtask

    task automatic measure(string tag, int n);
        longint t0;
        int guard = 0;
        while (!osc_en && guard < 100) begin cyc(1); guard++; end
        t0 = osc_edges;
        guard = 0;
        while (!clk_stable && guard < 20000) begin cyc(1); guard++; end
        check(tag, clk_stable && (osc_edges - t0) >= n && (osc_edges - t0) <= n + SLACK,
              osc_edges - t0, n);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint t0;
        bit     ok;
        bit     prev_rst;
        int     p0;
        cyc(8);
        // R1: reset state
        check("R1 osc_en", osc_en === 1'b1, osc_en, 1);
        check("R1 cpu_rst_n", cpu_rst_n === 1'b0, cpu_rst_n, 0);
        check("R1 clk_stable", clk_stable === 1'b0, clk_stable, 0);
        check("R1 pclk quiet", pulses == 0, pulses, 0);

        // R2/R3: cold count with disturbing inputs in the first 200 cycles
        por = 1'b0;
        t0 = osc_edges;
        ok = 1'b1;
        for (int k = 0; k < 200; k++) begin
            stop_req = (k == 20);
            enosc    = !(k >= 40 && k < 90);
            wake_irq = (k == 120);
            cyc(1);
            if (!(osc_en === 1'b1 && cpu_rst_n === 1'b0)) ok = 1'b0;
        end
        stop_req = 1'b0; wake_irq = 1'b0; enosc = 1'b1;
        check("R3 inputs ignored while cold", ok, ok, 1);
        prev_rst = cpu_rst_n;
        while (!clk_stable && (osc_edges - t0) < 3 * COLD_N) begin
            prev_rst = cpu_rst_n;
            cyc(1);
        end
        check("R2 cold window", (osc_edges - t0) >= COLD_N && (osc_edges - t0) <= COLD_N + SLACK,
              osc_edges - t0, COLD_N);
        check("R2 cpu release with clock", cpu_rst_n === 1'b1 && prev_rst === 1'b0,
              {prev_rst, cpu_rst_n}, 2'b01);

        // R8: pclk runs while stable
        cyc(3);
        p0 = pulses;
        cyc(20);
        check("R8 pclk running", (pulses - p0) >= 45 && (pulses - p0) <= 51, pulses - p0, 50);

        // R10: wake ignored while running
        pulse_wake();
        cyc(3);
        check("R10 wake ignored in on", clk_stable === 1'b1, clk_stable, 1);

        // R4: stop
        pulse_stop();
        check("R4 osc off after stop", osc_en === 1'b0, osc_en, 0);
        check("R4 not stable after stop", clk_stable === 1'b0, clk_stable, 0);
        cyc(10);
        p0 = pulses;
        cyc(20);
        check("R4 pclk stopped", pulses == p0, pulses - p0, 0);

        // R5: wake restart
        pulse_wake();
        check("R5 osc on after wake", osc_en === 1'b1, osc_en, 1);
        measure("R5 wake window", WARM_N);

        // R6: software clear and set
        enosc = 1'b0;
        cyc(1);
        check("R6 osc off after clear", osc_en === 1'b0, osc_en, 0);
        cyc(10);
        pulse_wake();
        cyc(3);
        check("R10 wake ignored in off", osc_en === 1'b0, osc_en, 0);
        enosc = 1'b1;
        measure("R6 software restart window", WARM_N);

        // R7: aborted restarts at several points of the count
        for (int k = 4; k <= 44; k += 8) begin
            pulse_stop();
            cyc(5);
            pulse_wake();
            cyc(k);
            check("R7 still counting", clk_stable === 1'b0, clk_stable, 0);
            pulse_stop();
            check("R7 abort stops osc", osc_en === 1'b0, osc_en, 0);
            cyc(3);
            pulse_wake();
            measure("R7 full count after abort", WARM_N);
        end

        // R9: stop wins over enosc low; sleep ignores enosc alone
        enosc = 1'b0; stop_req = 1'b1;
        cyc(1);
        stop_req = 1'b0; enosc = 1'b1;
        cyc(5);
        check("R9 sleep ignores enosc", osc_en === 1'b0, osc_en, 0);
        enosc = 1'b0;
        pulse_wake();
        cyc(3);
        check("R9 wake with enosc low stays off", osc_en === 1'b0, osc_en, 0);
        enosc = 1'b1;
        measure("R9 off restarts on enosc", WARM_N);

        // R8: glitch-free gating over the whole run
        check("R8 pulse widths and gating", glitch_bad == 0 && pulses > 0, glitch_bad, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule